// File: doc/BRIEF.md
# E1 Time-Slot-0 Transmit Word Generator

This block produces the time-slot-0 byte of each outgoing E1 frame in doubleframe format and shifts it out serially. Frames alternate between a frame-alignment word and a service word, starting with the frame-alignment word after reset. The service word carries the international spare bit, a fixed 1, the remote-alarm bit and five national spare bits. The national bits come either from a register field or, when stack mode is on, from a separate spare-bit stack input.

Three transparent modes let a system-side byte replace some or all of the generated content. The full mode passes the whole system byte in every frame. The extended mode also passes the system byte in every frame, but keeps the internal remote-alarm bit in service frames. The service-only mode passes the system byte in service frames, again keeping the internal alarm bit, and keeps the internal alignment pattern in alignment frames. When more than one mode is requested, the full mode wins over the extended mode, and the extended mode wins over the service-only mode.

A one-cycle strobe marks the start of time slot 0. All inputs are captured on that cycle, so a byte never mixes two settings. The byte is then sent over the next eight cycles, bit 1 first.

Top module: `e1_ts0_tx`

## Requirements
- R1: After reset, tx_valid_o is 0 and tx_bit_o is 1. tx_bit_o stays 1 whenever tx_valid_o is 0. The first frame after reset is an alignment frame.
- R2: Each ts0_start_i pulse switches the frame type, so frames go alignment, service, alignment, and so on.
- R3: With no transparent mode, an alignment frame sends bit 1 = intl_spare_i and bits 2 to 8 = 0,0,1,1,0,1,1.
- R4: With no transparent mode and stack mode off, a service frame sends bit 1 = intl_spare_i, bit 2 = 1, bit 3 = rem_alarm_i, and bits 4 to 8 = nat_spare_i[4] down to nat_spare_i[0].
- R5: With stack mode on and no transparent mode, bits 4 to 8 of a service frame are stack_bits_i[4] down to stack_bits_i[0], and nat_spare_i has no effect.
- R6: The cycle after ts0_start_i, tx_valid_o rises. It stays high for exactly 8 cycles while bit 1 to bit 8 go out, one per cycle. A new ts0_start_i during a byte restarts the output with the new byte.
- R7: In full transparent mode (tt_full_i=1), the byte is sys_ts0_i in both frame types, with bit 1 = sys_ts0_i[7] and bit 8 = sys_ts0_i[0]. All register fields have no effect.
- R8: In extended mode, the byte is sys_ts0_i in alignment frames. In service frames it is sys_ts0_i with bit 3 replaced by rem_alarm_i. Spare-bit fields have no effect.
- R9: In service-only mode, an alignment frame sends bit 1 = sys_ts0_i[7] and bits 2 to 8 = 0011011. A service frame sends sys_ts0_i with bit 3 replaced by rem_alarm_i. Spare-bit fields have no effect.
- R10: When several mode enables are set, tt_full_i takes priority over tt_ext_i, and tt_ext_i takes priority over tt_svc_i.
- R11: Inputs are sampled only in the ts0_start_i cycle. Changing them while a byte is being sent does not alter that byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bit clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ts0_start_i | input | 1 | One-cycle strobe marking the start of time slot 0 |
| intl_spare_i | input | 1 | International spare bit |
| rem_alarm_i | input | 1 | Remote-alarm request |
| nat_spare_i | input | 5 | National spare bits from register |
| stack_en_i | input | 1 | Take national bits from the stack input |
| stack_bits_i | input | 5 | National spare bits from the stack |
| tt_full_i | input | 1 | Full transparent mode enable |
| tt_ext_i | input | 1 | Extended transparent mode enable |
| tt_svc_i | input | 1 | Service-only transparent mode enable |
| sys_ts0_i | input | 8 | System time-slot-0 byte, bit 7 is sent first |
| tx_bit_o | output | 1 | Serial time-slot-0 bit |
| tx_valid_o | output | 1 | High while a byte is being sent |

## Verification
The assertions check on every cycle that the idle line stays at mark and that each strobe starts a byte. They also check that each strobe switches the frame type, that bit 1 follows the system byte in full mode and the spare bit in a normal alignment frame, and that bit 3 of a service frame carries the alarm request unless the full mode is on. The bench sweeps every combination of the three mode enables together with stack mode, alarm, spare bit and several data patterns. That sweep is what shows the whole byte under each mode, the priority between modes, the stack-versus-register choice, and that a frame is unaffected when its inputs change mid-byte. Restart of a byte in flight is also shown only by a directed bench scenario.

// File: rtl/e1_ts0_pkg.sv
package e1_ts0_pkg;
  localparam int WORD_W = 8;
  localparam int NAT_W  = WORD_W - 3;
  localparam int CNT_W  = $clog2(WORD_W + 1);
  // vector index of 1-based line bit n (bit 1 leaves first)
  localparam int B1 = WORD_W - 1;
  localparam int B2 = WORD_W - 2;
  localparam int B3 = WORD_W - 3;
  localparam logic [WORD_W-2:0] FAS_TAIL = 7'b0011011;

  typedef enum logic [1:0] {
    TM_NONE = 2'd0,
    TM_SVC  = 2'd1,
    TM_EXT  = 2'd2,
    TM_FULL = 2'd3
  } tmode_e;
endpackage

// File: rtl/e1_ts0_mode_sel.sv
module e1_ts0_mode_sel
  import e1_ts0_pkg::*;
(
  input  logic   full_i,
  input  logic   ext_i,
  input  logic   svc_i,
  output tmode_e mode_o
);
  always_comb begin
    if (full_i)      mode_o = TM_FULL;
    else if (ext_i)  mode_o = TM_EXT;
    else if (svc_i)  mode_o = TM_SVC;
    else             mode_o = TM_NONE;
  end
endmodule

// File: rtl/e1_ts0_word_build.sv
module e1_ts0_word_build
  import e1_ts0_pkg::*;
(
  input  logic              svc_frame_i,
  input  tmode_e            mode_i,
  input  logic              si_i,
  input  logic              ra_i,
  input  logic [NAT_W-1:0]  nat_i,
  input  logic              stack_en_i,
  input  logic [NAT_W-1:0]  stack_i,
  input  logic [WORD_W-1:0] sys_i,
  output logic [WORD_W-1:0] word_o
);
  logic [NAT_W-1:0]  nat_sel;
  logic [WORD_W-1:0] fas_w;
  logic [WORD_W-1:0] svc_w;
  logic [WORD_W-1:0] sys_keep_ra;

  assign nat_sel = stack_en_i ? stack_i : nat_i;
  assign fas_w   = {si_i, FAS_TAIL};
  assign svc_w   = {si_i, 1'b1, ra_i, nat_sel};

  always_comb begin
    sys_keep_ra     = sys_i;
    sys_keep_ra[B3] = ra_i;
  end

  always_comb begin
    unique case (mode_i)
      TM_FULL: word_o = sys_i;
      TM_EXT:  word_o = svc_frame_i ? sys_keep_ra : sys_i;
      TM_SVC:  word_o = svc_frame_i ? sys_keep_ra : {sys_i[B1], FAS_TAIL};
      default: word_o = svc_frame_i ? svc_w : fas_w;
    endcase
  end
endmodule

// File: rtl/e1_ts0_serializer.sv
module e1_ts0_serializer #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] word_i,
  output logic         bit_o,
  output logic         valid_o
);
  localparam int CW = $clog2(W + 1);

  logic [W-1:0]  sh_q;
  logic [CW-1:0] cnt_q;

  // ones shift in from the bottom so the line idles at mark
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q  <= '1;
      cnt_q <= '0;
    end else if (load_i) begin
      sh_q  <= word_i;
      cnt_q <= CW'(W);
    end else if (cnt_q != '0) begin
      sh_q  <= {sh_q[W-2:0], 1'b1};
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign bit_o   = sh_q[W-1];
  assign valid_o = (cnt_q != '0);

  assert_idle_mark_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> bit_o);

  assert_load_valid_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> valid_o);
endmodule

// File: rtl/e1_ts0_tx.sv
module e1_ts0_tx
  import e1_ts0_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       ts0_start_i,
  input  logic       intl_spare_i,
  input  logic       rem_alarm_i,
  input  logic [4:0] nat_spare_i,
  input  logic       stack_en_i,
  input  logic [4:0] stack_bits_i,
  input  logic       tt_full_i,
  input  logic       tt_ext_i,
  input  logic       tt_svc_i,
  input  logic [7:0] sys_ts0_i,
  output logic       tx_bit_o,
  output logic       tx_valid_o
);
  logic              frame_svc_q;
  tmode_e            mode;
  logic [WORD_W-1:0] word;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          frame_svc_q <= 1'b0;
    else if (ts0_start_i) frame_svc_q <= ~frame_svc_q;
  end

  e1_ts0_mode_sel u_mode (
    .full_i (tt_full_i),
    .ext_i  (tt_ext_i),
    .svc_i  (tt_svc_i),
    .mode_o (mode)
  );

  e1_ts0_word_build u_build (
    .svc_frame_i (frame_svc_q),
    .mode_i      (mode),
    .si_i        (intl_spare_i),
    .ra_i        (rem_alarm_i),
    .nat_i       (nat_spare_i),
    .stack_en_i  (stack_en_i),
    .stack_i     (stack_bits_i),
    .sys_i       (sys_ts0_i),
    .word_o      (word)
  );

  e1_ts0_serializer #(.W(WORD_W)) u_ser (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (ts0_start_i),
    .word_i  (word),
    .bit_o   (tx_bit_o),
    .valid_o (tx_valid_o)
  );

  assert_frame_toggle_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ts0_start_i |=> (frame_svc_q != $past(frame_svc_q)));

  assert_fas_spare_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ts0_start_i && !frame_svc_q && !tt_full_i && !tt_ext_i && !tt_svc_i)
      |=> (tx_bit_o == $past(intl_spare_i)));

  assert_full_bit1_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ts0_start_i && tt_full_i) |=> (tx_bit_o == $past(sys_ts0_i[7])));

  // bit 3 of a service frame carries the alarm in every mode but full (R8, R9 too)
  assert_alarm_bit_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ts0_start_i && frame_svc_q && !tt_full_i) ##1 !ts0_start_i ##1 !ts0_start_i
      |=> (tx_bit_o == $past(rem_alarm_i, 3)));
endmodule

// File: tb/tb_e1_ts0_tx.sv
module tb_e1_ts0_tx;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       ts0_start_i = 1'b0;
  logic       intl_spare_i, rem_alarm_i, stack_en_i;
  logic       tt_full_i, tt_ext_i, tt_svc_i;
  logic [4:0] nat_spare_i, stack_bits_i;
  logic [7:0] sys_ts0_i;
  logic       tx_bit_o, tx_valid_o;

  int total = 0;
  int bad = 0;
  bit done = 0;
  bit parity = 0;

  logic v_si, v_ra, v_se, v_full, v_ext, v_svc;
  logic [4:0] v_nat, v_stk;
  logic [7:0] v_sys;

  always #2.5 clk_i = ~clk_i;

  e1_ts0_tx dut (.*);

  initial begin
    for (int c = 0; c < 150000; c++) begin
      @(posedge clk_i);
      if (done) break;
    end
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  function automatic logic [7:0] ref_word(bit svc);
    logic [7:0] ka;
    ka = v_sys; ka[5] = v_ra;
    if (v_full)     return v_sys;
    else if (v_ext) return svc ? ka : v_sys;
    else if (v_svc) return svc ? ka : {v_sys[7], 7'b0011011};
    else            return svc ? {v_si, 1'b1, v_ra, (v_se ? v_stk : v_nat)}
                               : {v_si, 7'b0011011};
  endfunction

  function automatic string tag_of(bit svc);
    string t;
    if (v_full)     t = "R7";
    else if (v_ext) t = "R8";
    else if (v_svc) t = "R9";
    else if (!svc)  t = "R3";
    else if (v_se)  t = "R5";
    else            t = "R4";
    if (int'(v_full) + int'(v_ext) + int'(v_svc) > 1) t = {t, "/R10"};
    return {t, "/R2/R11"};
  endfunction

  task automatic apply(bit inv);
    intl_spare_i = v_si ^ inv;   rem_alarm_i = v_ra ^ inv;
    stack_en_i   = v_se ^ inv;   nat_spare_i = v_nat ^ {5{inv}};
    stack_bits_i = v_stk ^ {5{inv}};
    tt_full_i = v_full ^ inv; tt_ext_i = v_ext ^ inv; tt_svc_i = v_svc ^ inv;
    sys_ts0_i = v_sys ^ {8{inv}};
  endtask

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  // called at a negedge; sends one frame and checks it
  task automatic run_frame();
    logic [7:0] exp, rx;
    bit vok;
    string t;
    exp = ref_word(parity);
    t = tag_of(parity);
    parity = ~parity;
    apply(0);
    ts0_start_i = 1'b1;
    @(negedge clk_i);
    ts0_start_i = 1'b0;
    apply(1);  // R11: disturb inputs mid-byte
    vok = 1;
    for (int i = 0; i < 8; i++) begin
      rx[7-i] = tx_bit_o;
      if (tx_valid_o !== 1'b1) vok = 0;
      @(negedge clk_i);
    end
    if (tx_valid_o !== 1'b0 || tx_bit_o !== 1'b1) vok = 0;
    check(t, rx, exp);
    check("R6", {7'd0, vok}, 8'd1);
  endtask

  initial begin
    v_si = 1; v_ra = 0; v_se = 0; v_full = 0; v_ext = 0; v_svc = 0;
    v_nat = 5'h1f; v_stk = 5'h1f; v_sys = 8'h00;
    apply(0);
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1", {6'd0, tx_valid_o, tx_bit_o}, 8'h01);
    // R1: first frame after reset is alignment
    v_si = 0;
    run_frame();

    for (int m = 0; m < 8; m++)
      for (int se = 0; se < 2; se++)
        for (int ra = 0; ra < 2; ra++)
          for (int si = 0; si < 2; si++)
            for (int p = 0; p < 4; p++)
              for (int f = 0; f < 2; f++) begin
                v_full = m[2]; v_ext = m[1]; v_svc = m[0];
                v_se = se[0]; v_ra = ra[0]; v_si = si[0];
                v_nat = 5'(p * 7 + 3 + f);
                v_stk = 5'(p * 11 + 20 + 3 * f);
                v_sys = 8'(p * 53 + 8'h96 + 29 * f);
                run_frame();
              end

    // R6: restart during a byte
    v_full = 0; v_ext = 0; v_svc = 0; v_se = 0; v_ra = 1; v_si = 1;
    v_nat = 5'h0a; v_sys = 8'h3c;
    apply(0);
    ts0_start_i = 1'b1;
    parity = ~parity;
    @(negedge clk_i);
    ts0_start_i = 1'b0;
    repeat (3) @(negedge clk_i);
    v_ra = 0; v_si = 0; v_nat = 5'h15;
    run_frame();
    v_ra = 1; v_nat = 5'h11;
    run_frame();

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule